// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a register-mapped watchdog for a chip's system bus. A 32-bit up-counter advances on a slow timebase tick (nominally 32.768 kHz, delivered as a one-clock pulse on `tick_in`). An optional power-of-two prescaler stretches the advance interval. When the counter steps from all-ones to zero, the block raises a one-clock reset request. Software arms a timeout of N seconds by loading the value 2^32 minus N times the tick rate. It then keeps the system alive by writing a new value to the trigger register, which reloads the counter from the load register.

The counter can only be started or halted through an ordered pair of key words written to the key register. This guards against a runaway program that writes the wrong thing. Every register write also sets a posting-status bit. The bit stays set for a fixed number of timebase ticks, which emulates the time the write would need to reach a slow clock domain. Software polls these bits before it continues.

The key state machine has four states:
- `KS_HALTED`: the counter is stopped.
- `KS_START_ARMED`: the first start word has been seen.
- `KS_COUNTING`: the counter is running.
- `KS_STOP_ARMED`: the counter is running and the first stop word has been seen.

Its transitions, each taken on a key register write:
- **arm-start**: from `KS_HALTED` on 0xBBBB.
- **start**: from `KS_START_ARMED` to `KS_COUNTING` on 0x4444.
- **re-arm**: `KS_START_ARMED` stays where it is on a repeated 0xBBBB.
- **cancel-start**: from `KS_START_ARMED` back to `KS_HALTED` on any other word.
- **arm-stop**: from `KS_COUNTING` on 0xAAAA.
- **stop**: from `KS_STOP_ARMED` to `KS_HALTED` on 0x5555.
- **re-arm-stop**: `KS_STOP_ARMED` stays where it is on a repeated 0xAAAA.
- **cancel-stop**: from `KS_STOP_ARMED` back to `KS_COUNTING` on any other word.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the following are all zero: control, counter, load, trigger, key register readback and posting status. The key machine is in `KS_HALTED`, so the counter does not move, and `rst_req` is low.
- R2: A read of offset 0x00 returns the revision, with the major number in bits 7:4 and the minor number in bits 3:0 (default 0x10). All other bits read zero.
- R3: Only the low 16 bits of a key write (offset 0x48) are compared. Writing 0xBBBB and then 0x4444 starts the counter. The first advance can follow on the tick after the edge that accepts 0x4444.
- R4: Writing 0xAAAA and then 0x5555 to offset 0x48 stops the counter. While it is stopped, the counter holds its value.
- R5: In an armed state, a wrong key word cancels the partial sequence, and the pair must then restart from its first word. A repeat of the first word keeps the machine armed. Words that are not a valid first word are ignored in `KS_HALTED` and `KS_COUNTING`.
- R6: While the counter runs with control bit 5 clear, it gains one on every tick. With bit 5 set, it gains one every 2^P ticks, where P is control bits 4:2. The tick divider restarts at every control write and whenever the counter is halted.
- R7: When the counter advances from 0xFFFFFFFF, it becomes 0 and `rst_req` is high for exactly the next clock.
- R8: Offset 0x28 reads and writes the counter directly. A write takes priority over an advance in the same cycle, and it suppresses the reset request for that cycle.
- R9: A write to the trigger register (0x30) whose value differs from the stored trigger value copies the load register (0x2C) into the counter. A write of the same value leaves the counter untouched.
- R10: Offset 0x34 reads the posting status. Bit 0 is control, bit 1 is counter, bit 2 is load, bit 3 is trigger and bit 4 is key. A bit is set from the clock after a write to its register, and it clears after POST_TICKS further ticks (default 2).
- R11: Offset 0x48 reads back the last key word written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-clock timebase pulse |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-clock reset request on counter wrap |

## Verification
The counter is driven in several ways: halted, running on every tick, running under prescale 4, reloaded by triggers with a fresh or a repeated value, and loaded close to all-ones so that it wraps. These cases separate three faults: a wrong advance rate, a missing or duplicated reload, and a reset pulse of the wrong width or in the wrong cycle. The key register receives correct pairs, reversed pairs, pairs with a foreign word in between, and repeated first words, which separates a machine that cancels a broken sequence from one that only remembers the last word. The posting bits are polled immediately after a write and again some ticks later, which shows both that the bit is set and that it expires on time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 8;
    localparam int KEY_W  = 16;
    localparam int NPOST  = 5;

    typedef enum logic [1:0] {
        KS_HALTED,
        KS_START_ARMED,
        KS_COUNTING,
        KS_STOP_ARMED
    } key_state_e;

    localparam logic [ADDR_W-1:0] OFS_ID   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_POST = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h48;

    localparam logic [KEY_W-1:0] KEY_GO_A   = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_GO_B   = 16'h4444;
    localparam logic [KEY_W-1:0] KEY_HALT_A = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_HALT_B = 16'h5555;

endpackage

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_word,
    output logic             running
);

    key_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            unique case (st_q)
                KS_HALTED: begin
                    if (key_word == KEY_GO_A) st_d = KS_START_ARMED;
                end
                KS_START_ARMED: begin
                    if (key_word == KEY_GO_B)      st_d = KS_COUNTING;
                    else if (key_word == KEY_GO_A) st_d = KS_START_ARMED;
                    else                           st_d = KS_HALTED;
                end
                KS_COUNTING: begin
                    if (key_word == KEY_HALT_A) st_d = KS_STOP_ARMED;
                end
                KS_STOP_ARMED: begin
                    if (key_word == KEY_HALT_B)      st_d = KS_HALTED;
                    else if (key_word == KEY_HALT_A) st_d = KS_STOP_ARMED;
                    else                             st_d = KS_COUNTING;
                end
                default: st_d = KS_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KS_HALTED;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            KS_COUNTING, KS_STOP_ARMED: running = 1'b1;
            default:                    running = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clear,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             adv
);

    localparam int DIV_W = (1 << PTV_W);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim = ({{(DIV_W-1){1'b0}}, 1'b1} << ptv) - {{(DIV_W-1){1'b0}}, 1'b1};
    assign adv = run && tick && (!pre_en || (div_q == lim));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || clear) div_q <= '0;
        else if (tick)               div_q <= adv ? '0 : div_q + 1'b1;
    end

endmodule

// File: rtl/wdt_postsim.sv
module wdt_postsim #(
    parameter int NREG       = 5,
    parameter int POST_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] pending
);

    localparam int PC_W = $clog2(POST_TICKS + 1);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic [PC_W-1:0] pc_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                 pc_q <= '0;
            else if (wr_hit[g])         pc_q <= PC_W'(POST_TICKS);
            else if (tick && pc_q != 0) pc_q <= pc_q - 1'b1;
        end
        assign pending[g] = (pc_q != '0);
    end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int         CNT_W      = 32,
    parameter int         PTV_W      = 3,
    parameter int         POST_TICKS = 2,
    parameter logic [3:0] REV_MAJOR  = 4'd1,
    parameter logic [3:0] REV_MINOR  = 4'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              rst_req
);

    localparam int PRE_BIT = PTV_W + 2;

    logic             pre_en_q;
    logic [PTV_W-1:0] ptv_q;
    logic [CNT_W-1:0] cnt_q, load_q, trig_q, key_q;
    logic             run, adv, trig_fire;
    logic             wr_ctrl, wr_cnt, wr_load, wr_trig, wr_key;
    logic [NPOST-1:0] pend;

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_cnt    = bus_wr && (bus_addr == OFS_CNT);
    assign wr_load   = bus_wr && (bus_addr == OFS_LOAD);
    assign wr_trig   = bus_wr && (bus_addr == OFS_TRIG);
    assign wr_key    = bus_wr && (bus_addr == OFS_KEY);
    assign trig_fire = wr_trig && (bus_wdata != trig_q);

    wdt_keyfsm u_keyfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_key),
        .key_word (bus_wdata[KEY_W-1:0]),
        .running  (run)
    );

    wdt_prescale #(.PTV_W(PTV_W)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_in),
        .run    (run),
        .clear  (wr_ctrl),
        .pre_en (pre_en_q),
        .ptv    (ptv_q),
        .adv    (adv)
    );

    wdt_postsim #(.NREG(NPOST), .POST_TICKS(POST_TICKS)) u_postsim (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_in),
        .wr_hit  ({wr_key, wr_trig, wr_load, wr_cnt, wr_ctrl}),
        .pending (pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en_q <= 1'b0;
            ptv_q    <= '0;
            load_q   <= '0;
            trig_q   <= '0;
            key_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                pre_en_q <= bus_wdata[PRE_BIT];
                ptv_q    <= bus_wdata[PRE_BIT-1:2];
            end
            if (wr_load) load_q <= bus_wdata;
            if (wr_trig) trig_q <= bus_wdata;
            if (wr_key)  key_q  <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= adv && (&cnt_q) && !wr_cnt && !trig_fire;
            if (wr_cnt)         cnt_q <= bus_wdata;
            else if (trig_fire) cnt_q <= load_q;
            else if (adv)       cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ID:   bus_rdata = CNT_W'({REV_MAJOR, REV_MINOR});
            OFS_CTRL: bus_rdata = CNT_W'({pre_en_q, ptv_q, 2'b00});
            OFS_CNT:  bus_rdata = cnt_q;
            OFS_LOAD: bus_rdata = load_q;
            OFS_TRIG: bus_rdata = trig_q;
            OFS_POST: bus_rdata = CNT_W'(pend);
            OFS_KEY:  bus_rdata = key_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic              rst_req,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [NPOST-1:0]  pend
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7

    AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == '0)); // R7

    AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(cnt)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bus_wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R6

    AST_START_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(bus_wr && bus_addr == OFS_KEY && bus_wdata[KEY_W-1:0] == KEY_GO_B)); // R3

    AST_STOP_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(bus_wr && bus_addr == OFS_KEY && bus_wdata[KEY_W-1:0] == KEY_HALT_B)); // R4

    AST_POST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> pend[0]); // R10

endmodule

bind keyed_wdt wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rst_req   (rst_req),
    .run       (run),
    .cnt       (cnt_q),
    .pend      (pend)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h28;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tcnt = 0;
    bit done = 0;

    keyed_wdt u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt    = 0;
            tick_in = 1'b0;
        end else begin
            tcnt    = tcnt + 1;
            tick_in = (tcnt % 4 == 0);
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt, m_load, m_trig, m_key;
    bit          m_pre, m_rst;
    int          m_ptv, m_div, m_state;
    int          m_pc[5];
    bit          m_run, m_adv, m_wcnt, m_fire;
    logic [7:0]  ofs_tab[5] = '{8'h24, 8'h28, 8'h2C, 8'h30, 8'h48};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_trig = 0; m_key = 0;
            m_pre = 0; m_rst = 0; m_ptv = 0; m_div = 0; m_state = 0;
            foreach (m_pc[i]) m_pc[i] = 0;
        end else begin
            m_run = (m_state >= 2);
            m_adv = 0;
            if (m_run && tick_in) begin
                if (!m_pre) m_adv = 1;
                else if (m_div == (1 << m_ptv) - 1) m_adv = 1;
            end
            if (!m_run || (bus_wr && bus_addr == 8'h24)) m_div = 0;
            else if (tick_in) m_div = m_adv ? 0 : m_div + 1;
            m_wcnt = bus_wr && bus_addr == 8'h28;
            m_fire = bus_wr && bus_addr == 8'h30 && bus_wdata != m_trig;
            m_rst  = m_adv && m_cnt == 32'hFFFF_FFFF && !m_wcnt && !m_fire;
            if (m_wcnt)      m_cnt = bus_wdata;
            else if (m_fire) m_cnt = m_load;
            else if (m_adv)  m_cnt = m_cnt + 1;
            for (int i = 0; i < 5; i++) begin
                if (bus_wr && bus_addr == ofs_tab[i]) m_pc[i] = 2;
                else if (tick_in && m_pc[i] > 0)     m_pc[i] = m_pc[i] - 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h24: begin m_pre = bus_wdata[5]; m_ptv = int'(bus_wdata[4:2]); end
                    8'h2C: m_load = bus_wdata;
                    8'h30: m_trig = bus_wdata;
                    8'h48: begin
                        m_key = bus_wdata;
                        case (m_state)
                            0: if (bus_wdata[15:0] == 16'hBBBB) m_state = 1;
                            1: m_state = (bus_wdata[15:0] == 16'h4444) ? 2 :
                                         (bus_wdata[15:0] == 16'hBBBB) ? 1 : 0;
                            2: if (bus_wdata[15:0] == 16'hAAAA) m_state = 3;
                            default: m_state = (bus_wdata[15:0] == 16'h5555) ? 0 :
                                               (bus_wdata[15:0] == 16'hAAAA) ? 3 : 2;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] p;
        p = '0;
        for (int i = 0; i < 5; i++) p[i] = (m_pc[i] != 0);
        case (a)
            8'h00: return 32'h10;
            8'h24: return {26'd0, m_pre, 3'(m_ptv), 2'b00};
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h30: return m_trig;
            8'h34: return p;
            8'h48: return m_key;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(bus_addr == 8'h34 ? "R10" : bus_addr == 8'h28 ? "R6" : "R11",
                bus_rdata, exp_read(bus_addr));
            chk("R7", {31'd0, rst_req}, {31'd0, m_rst});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h28;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, v2;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(8'h24, v); chk("R1 control", v, 0);
        rd(8'h28, v); chk("R1 counter", v, 0);
        rd(8'h34, v); chk("R1 posting", v, 0);
        chk("R1 rst_req", {31'd0, rst_req}, 0);
        rd(8'h00, v); chk("R2 revision", v, 32'h10);
        rd(8'h04, v); chk("R11 unmapped", v, 0);
        bus_addr = 8'h28;

        // halted counter holds a written value
        wr(8'h28, 32'd100);
        rd(8'h34, v); chk("R10 counter pending", v & 32'h2, 32'h2);
        idle(40);
        rd(8'h28, v); chk("R8 write while halted", v, 32'd100);
        rd(8'h34, v); chk("R10 pending cleared", v, 0);

        // broken start sequences
        wr(8'h48, 32'h4444); wr(8'h48, 32'hBBBB); wr(8'h48, 32'h1234); wr(8'h48, 32'h4444);
        idle(40);
        rd(8'h28, v); chk("R5 broken start ignored", v, 32'd100);
        rd(8'h48, v); chk("R11 key readback", v, 32'h4444);

        // repeated first word keeps the machine armed
        wr(8'h48, 32'hBBBB); wr(8'h48, 32'hBBBB); wr(8'h48, 32'hFFFF_4444);
        idle(40);
        rd(8'h28, v); chk("R3 started", {31'd0, v > 32'd105}, 1);

        // trigger reload
        wr(8'h2C, 32'h200);
        rd(8'h34, v); chk("R10 load pending", v & 32'h4, 32'h4);
        wr(8'h30, 32'd5);
        rd(8'h28, v); chk("R9 reload", {31'd0, v >= 32'h200 && v <= 32'h201}, 1);
        idle(24);
        rd(8'h28, v);
        wr(8'h30, 32'd5);
        rd(8'h28, v2); chk("R9 same value no reload", {31'd0, v2 >= v && v2 > 32'h201}, 1);

        // prescaler by 4
        wr(8'h24, 32'h28);
        wr(8'h28, 32'd0);
        idle(160);
        rd(8'h28, v); chk("R6 prescale rate", {31'd0, v >= 32'd9 && v <= 32'd10}, 1);

        // broken stop, then a proper stop
        wr(8'h48, 32'hAAAA); wr(8'h48, 32'h1111); wr(8'h48, 32'h5555);
        rd(8'h28, v); idle(40); rd(8'h28, v2);
        chk("R5 broken stop keeps running", {31'd0, v2 > v}, 1);
        wr(8'h48, 32'hAAAA); wr(8'h48, 32'h5555);
        rd(8'h28, v); idle(40); rd(8'h28, v2);
        chk("R4 stopped holds", v2, v);

        // expiry from a near-wrap value
        wr(8'h24, 32'h0);
        wr(8'h28, 32'hFFFF_FF80);
        wr(8'h48, 32'hBBBB); wr(8'h48, 32'h4444);
        hi = 0;
        for (int i = 0; i < 2000 && hi == 0; i++) begin
            @(posedge clk); #3;
            if (rst_req) hi = 1;
        end
        chk("R7 reset raised", hi, 1);
        rd(8'h28, v); chk("R7 wrapped to zero", v, 0);
        @(posedge clk); #3;
        chk("R7 one clock wide", {31'd0, rst_req}, 0);

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule